// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus and judges every access against a table of programmable protection regions. Each region describes a naturally aligned, power-of-two sized window of the address space, may have any of its eight equal slices switched off, and carries a permission code that grants different rights to privileged and unprivileged requesters. The verdict for the access on the inputs is produced combinationally, so the bus can use it in the same cycle. A denied access that is marked valid produces a one-cycle fault pulse on the next clock edge, together with the captured address of the offending access.

Regions and a global enable are loaded through a simple write port: a region index, a field selector and a 32-bit data word. A memory-attribute field is kept for each region and reported alongside the verdict, but the checker takes no decision from it. While the global enable is clear, the checker passes every access without judging it.

Top module: `memprot_checker`

## Requirements
- R1: After reset the global enable is clear, every region is disabled, `flt_pulse` is 0, `flt_addr` is 0 and `acc_allow` is 1.
- R2: While the global enable is clear, `acc_allow` is 1 for every access and no fault pulse is produced. The global enable is bit 0 of a write with `cfg_sel` = 2.
- R3: A write with `cfg_sel` = 0 sets the region base, and a write with `cfg_sel` = 1 sets the attribute word: bit 0 is the region enable, bits 5:1 the size exponent N, bits 15:8 the slice-off mask, bits 18:16 the permission code and bits 28:24 the memory attribute. A region covers 2^(N+1) bytes. Base bits below N+1 are ignored, and a disabled region never matches.
- R4: A region with N below 4 never matches. N = 4 gives a 32-byte region and N = 31 covers the whole 4 GB space.
- R5: A region is split into eight equal slices numbered from its low end. Setting mask bit k excludes slice k, and an address in that slice is treated as outside the region.
- R6: When several enabled regions match, the one with the highest index decides.
- R7: An address that no enabled region matches is allowed for privileged accesses and denied for unprivileged ones.
- R8: The permission codes, for a privileged / an unprivileged requester, are: 0 none/none, 1 RW/none, 2 RW/R, 3 RW/RW, 4 none/none, 5 R/none, 6 R/R, 7 R/R.
- R9: `acc_allow` and `acc_attr` follow the access inputs in the same cycle. `acc_attr` is the memory attribute of the deciding region and 0 when no region matches.
- R10: A valid, denied access raises `flt_pulse` for exactly the next cycle and loads `flt_addr` with its address. Otherwise `flt_pulse` is 0 and `flt_addr` holds its value, including when `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Region index for the write |
| cfg_sel | input | 2 | Field select: 0 base, 1 attributes, 2 global control |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_priv | input | 1 | 1 for a privileged requester |
| acc_allow | output | 1 | Access permitted (combinational) |
| acc_attr | output | 5 | Memory attribute of the deciding region |
| flt_pulse | output | 1 | One-cycle fault indication |
| flt_addr | output | 32 | Address of the latest faulting access |

## Verification
The verdict and attribute are due in the same cycle as the access, so the bench drives every access on a falling edge and samples `acc_allow` and `acc_attr` one nanosecond later, before any clock edge. The fault pulse and captured address pass through one register, so they are sampled on the following falling edge, after exactly one rising edge. Configuration writes are presented on a falling edge and take effect at the next rising edge, and no access that depends on them is checked before that edge. The reset input is synchronised through two stages, so the bench waits several cycles after releasing it before it checks the reset state.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

  parameter int unsigned MP_AW   = 32;
  parameter int unsigned MP_SZW  = 5;
  parameter int unsigned MP_SLW  = 8;
  parameter int unsigned MP_PW   = 3;
  parameter int unsigned MP_ATW  = 5;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_ATTR = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_RSVD = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [MP_ATW-1:0] mattr;
    logic [MP_PW-1:0]  perm;
    logic [MP_SLW-1:0] slice_off;
    logic [MP_SZW-1:0] szexp;
    logic              en;
    logic [MP_AW-1:0]  base;
  } region_cfg_t;

  localparam int unsigned MIN_SZEXP = 4;

  function automatic logic perm_ok(input logic [MP_PW-1:0] code,
                                   input logic             priv,
                                   input logic             wr);
    logic ok;
    case (code)
      3'd1:    ok = priv;
      3'd2:    ok = priv | ~wr;
      3'd3:    ok = 1'b1;
      3'd5:    ok = priv & ~wr;
      3'd6,
      3'd7:    ok = ~wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/memprot_rst_sync.sv
module memprot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/memprot_cfg_regs.sv
module memprot_cfg_regs
  import memprot_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [1:0]                   cfg_sel,
  input  logic [MP_AW-1:0]             cfg_wdata,
  output region_cfg_t [NUM_REGIONS-1:0] regions,
  output logic                         glb_en
);
  logic glb_en_d, glb_en_ce;
  logic unused_wbits;

  assign unused_wbits = ^{cfg_wdata[7:6], cfg_wdata[23:19], cfg_wdata[31:29]};

  always_comb begin
    glb_en_ce = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
    glb_en_d  = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         glb_en <= 1'b0;
    else if (glb_en_ce) glb_en <= glb_en_d;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    logic        base_ce, attr_ce;
    region_cfg_t cur_d;

    always_comb begin
      base_ce = cfg_we && (cfg_idx == IDX_W'(g)) && (cfg_sel_e'(cfg_sel) == SEL_BASE);
      attr_ce = cfg_we && (cfg_idx == IDX_W'(g)) && (cfg_sel_e'(cfg_sel) == SEL_ATTR);
      cur_d   = regions[g];
      if (base_ce) cur_d.base = cfg_wdata;
      if (attr_ce) begin
        cur_d.en        = cfg_wdata[0];
        cur_d.szexp     = cfg_wdata[5:1];
        cur_d.slice_off = cfg_wdata[15:8];
        cur_d.perm      = cfg_wdata[18:16];
        cur_d.mattr     = cfg_wdata[28:24];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  regions[g] <= '0;
      else if (base_ce || attr_ce) regions[g] <= cur_d;
    end
  end
endmodule

// File: rtl/memprot_region_match.sv
module memprot_region_match
  import memprot_pkg::*;
(
  input  logic              en,
  input  logic [MP_SZW-1:0] szexp,
  input  logic [MP_SLW-1:0] slice_off,
  input  logic [MP_AW-1:0]  base,
  input  logic [MP_AW-1:0]  addr,
  output logic              hit
);
  localparam int unsigned SLICE_LOG = $clog2(MP_SLW);

  logic [MP_AW-1:0]     cmp_mask;
  logic [MP_SZW:0]      span_log;
  logic [SLICE_LOG-1:0] slice_idx;
  logic                 size_ok, base_hit, slice_on;

  always_comb begin
    span_log  = {1'b0, szexp} + (MP_SZW+1)'(1);
    cmp_mask  = {MP_AW{1'b1}} << span_log;
    size_ok   = szexp >= MP_SZW'(MIN_SZEXP);
    base_hit  = ((addr ^ base) & cmp_mask) == '0;
    slice_idx = SLICE_LOG'(addr >> (szexp - MP_SZW'(SLICE_LOG - 1)));
    slice_on  = ~slice_off[slice_idx];
    hit       = en && size_ok && base_hit && slice_on;
  end
endmodule

// File: rtl/memprot_prio_sel.sv
module memprot_prio_sel
  import memprot_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16
) (
  input  logic [NUM_REGIONS-1:0]             hits,
  input  logic [NUM_REGIONS-1:0][MP_PW-1:0]  perms,
  input  logic [NUM_REGIONS-1:0][MP_ATW-1:0] mattrs,
  output logic                               any_hit,
  output logic [MP_PW-1:0]                   sel_perm,
  output logic [MP_ATW-1:0]                  sel_attr
);
  always_comb begin
    any_hit  = 1'b0;
    sel_perm = '0;
    sel_attr = '0;
    for (int i = 0; i < int'(NUM_REGIONS); i++) begin
      if (hits[i]) begin
        any_hit  = 1'b1;
        sel_perm = perms[i];
        sel_attr = mattrs[i];
      end
    end
  end
endmodule

// File: rtl/memprot_checker.sv
module memprot_checker
  import memprot_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [MP_AW-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic [MP_AW-1:0]  acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  output logic              acc_allow,
  output logic [MP_ATW-1:0] acc_attr,
  output logic              flt_pulse,
  output logic [MP_AW-1:0]  flt_addr
);
  logic                               rst_sync_n;
  logic                               glb_en;
  region_cfg_t [NUM_REGIONS-1:0]      regions;
  logic [NUM_REGIONS-1:0]             hits;
  logic [NUM_REGIONS-1:0][MP_PW-1:0]  perms;
  logic [NUM_REGIONS-1:0][MP_ATW-1:0] mattrs;
  logic                               any_hit;
  logic [MP_PW-1:0]                   sel_perm;
  logic                               flt_pulse_d, flt_addr_ce;

  memprot_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  memprot_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .regions(regions), .glb_en(glb_en)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    memprot_region_match u_match (
      .en(regions[g].en), .szexp(regions[g].szexp),
      .slice_off(regions[g].slice_off), .base(regions[g].base),
      .addr(acc_addr), .hit(hits[g])
    );
    assign perms[g]  = regions[g].perm;
    assign mattrs[g] = regions[g].mattr;
  end

  memprot_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hits(hits), .perms(perms), .mattrs(mattrs),
    .any_hit(any_hit), .sel_perm(sel_perm), .sel_attr(acc_attr)
  );

  always_comb begin
    if (!glb_en)      acc_allow = 1'b1;
    else if (any_hit) acc_allow = perm_ok(sel_perm, acc_priv, acc_write);
    else              acc_allow = acc_priv;
    flt_pulse_d = acc_valid && !acc_allow;
    flt_addr_ce = flt_pulse_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flt_pulse <= 1'b0;
    else             flt_pulse <= flt_pulse_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      flt_addr <= '0;
    else if (flt_addr_ce) flt_addr <= acc_addr;
  end
endmodule

// File: rtl/memprot_checker_sva.sv
module memprot_checker_sva
  import memprot_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             glb_en,
  input logic             acc_valid,
  input logic [MP_AW-1:0] acc_addr,
  input logic             acc_priv,
  input logic             acc_allow,
  input logic             flt_pulse,
  input logic [MP_AW-1:0] flt_addr
);
  AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !glb_en |-> acc_allow); // R2
  AST_PRIV_NEVER_BLOCKED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!glb_en && acc_valid) |=> !flt_pulse); // R2
  AST_FAULT_AFTER_DENY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && !acc_allow) |=> (flt_pulse && flt_addr == $past(acc_addr))); // R10
  AST_NO_FAULT_ON_ALLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(acc_valid && !acc_allow) |=> (!flt_pulse && $stable(flt_addr))); // R10
  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flt_pulse |-> $past(acc_valid)); // R10
endmodule

bind memprot_checker memprot_checker_sva u_sva (
  .clk(clk), .rst_sync_n(rst_sync_n), .glb_en(glb_en), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_allow(acc_allow),
  .flt_pulse(flt_pulse), .flt_addr(flt_addr)
);

// File: tb/tb_memprot_checker.sv
module tb_memprot_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        acc_valid, acc_write, acc_priv;
  logic [31:0] acc_addr;
  logic        acc_allow, flt_pulse;
  logic [4:0]  acc_attr;
  logic [31:0] flt_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] last_flt = '0;

  always #2.5 clk = ~clk;

  memprot_checker dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
    .acc_allow(acc_allow), .acc_attr(acc_attr), .flt_pulse(flt_pulse),
    .flt_addr(flt_addr)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] idx, input logic [1:0] sel,
                           input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_region(input logic [3:0] idx, input logic [31:0] base,
                            input logic en, input logic [4:0] n,
                            input logic [7:0] off, input logic [2:0] perm,
                            input logic [4:0] attr);
    cfg_write(idx, 2'd0, base);
    cfg_write(idx, 2'd1, {3'b0, attr, 5'b0, perm, off, 2'b0, n, en});
  endtask

  // Access at a falling edge: verdict now, fault one clock edge later.
  task automatic access(input logic v, input logic [31:0] a, input logic wr,
                        input logic pr, input logic exp_ok, input string req);
    logic exp_pulse;
    acc_valid = v; acc_addr = a; acc_write = wr; acc_priv = pr;
    #1;
    chk(acc_allow === exp_ok, req, 32'(acc_allow), 32'(exp_ok));
    exp_pulse = v && !exp_ok;
    if (exp_pulse) last_flt = a;
    @(negedge clk);
    chk(flt_pulse === exp_pulse, {req, " R10 pulse"}, 32'(flt_pulse), 32'(exp_pulse));
    chk(flt_addr === last_flt, {req, " R10 addr"}, flt_addr, last_flt);
    acc_valid = 1'b0;
  endtask

  function automatic logic exp_perm(input int code, input logic pr, input logic wr);
    logic pr_rd, pr_wr, us_rd, us_wr;
    pr_rd = (code inside {1, 2, 3, 5, 6, 7});
    pr_wr = (code inside {1, 2, 3});
    us_rd = (code inside {2, 3, 6, 7});
    us_wr = (code == 3);
    if (pr) return wr ? pr_wr : pr_rd;
    return wr ? us_wr : us_rd;
  endfunction

  task automatic t_reset;
    chk(acc_allow === 1'b1, "R1 allow", 32'(acc_allow), 1);
    chk(flt_pulse === 1'b0, "R1 pulse", 32'(flt_pulse), 0);
    chk(flt_addr === 32'h0, "R1 addr", flt_addr, 0);
    chk(acc_attr === 5'h0, "R1 attr", 32'(acc_attr), 0);
    access(1'b1, 32'h4000_0000, 1'b1, 1'b0, 1'b1, "R1 regions off");
  endtask

  task automatic t_disabled;
    set_region(4'd0, 32'h2000_0000, 1'b1, 5'd15, 8'h00, 3'd0, 5'h0A);
    acc_addr = 32'h2000_0010; #1;
    chk(acc_attr === 5'h0A, "R9 attr", 32'(acc_attr), 32'h0A);
    @(negedge clk);
    access(1'b1, 32'h2000_0010, 1'b1, 1'b0, 1'b1, "R2 no-access region ignored");
    access(1'b1, 32'h7000_0000, 1'b0, 1'b0, 1'b1, "R2 unmatched user");
  endtask

  task automatic t_background;
    cfg_write(4'd0, 2'd2, 32'h1);
    set_region(4'd0, 32'h2000_0000, 1'b0, 5'd15, 8'h00, 3'd3, 5'h0A);
    access(1'b1, 32'h1234_5678, 1'b0, 1'b0, 1'b0, "R7 user no match");
    access(1'b1, 32'h2000_0004, 1'b0, 1'b0, 1'b0, "R3 disabled region");
    access(1'b1, 32'h1234_5678, 1'b1, 1'b1, 1'b1, "R7 priv no match");
    acc_addr = 32'h1234_5678; #1;
    chk(acc_attr === 5'h0, "R9 attr no match", 32'(acc_attr), 0);
    @(negedge clk);
    access(1'b0, 32'h0BAD_0000, 1'b1, 1'b0, 1'b0, "R10 invalid no fault");
  endtask

  task automatic t_basic;
    set_region(4'd0, 32'h2000_1234, 1'b1, 5'd15, 8'h00, 3'd3, 5'h03);
    access(1'b1, 32'h2000_0000, 1'b1, 1'b0, 1'b1, "R3 low edge");
    access(1'b1, 32'h2000_FFFF, 1'b0, 1'b0, 1'b1, "R3 high edge");
    access(1'b1, 32'h2001_0000, 1'b0, 1'b0, 1'b0, "R3 above");
    access(1'b1, 32'h1FFF_FFFC, 1'b1, 1'b0, 1'b0, "R3 below");
  endtask

  task automatic t_perm;
    for (int c = 0; c < 8; c++) begin
      set_region(4'd0, 32'h2000_0000, 1'b1, 5'd15, 8'h00, 3'(c), 5'h03);
      for (int k = 0; k < 4; k++) begin
        logic pr, wr;
        pr = k[1]; wr = k[0];
        access(1'b1, 32'h2000_0100, wr, pr, exp_perm(c, pr, wr),
               $sformatf("R8 code %0d priv %0d wr %0d", c, pr, wr));
      end
    end
  endtask

  task automatic t_slices;
    set_region(4'd0, 32'h2000_0000, 1'b1, 5'd15, 8'h04, 3'd3, 5'h03);
    access(1'b1, 32'h2000_4000, 1'b0, 1'b0, 1'b0, "R5 slice 2 off");
    access(1'b1, 32'h2000_5FFC, 1'b1, 1'b0, 1'b0, "R5 slice 2 top");
    access(1'b1, 32'h2000_3FFC, 1'b1, 1'b0, 1'b1, "R5 slice 1 on");
    access(1'b1, 32'h2000_6000, 1'b0, 1'b0, 1'b1, "R5 slice 3 on");
    access(1'b1, 32'h2000_4000, 1'b1, 1'b1, 1'b1, "R5 priv falls back");
    set_region(4'd0, 32'h2000_0000, 1'b1, 5'd15, 8'h80, 3'd3, 5'h03);
    access(1'b1, 32'h2000_E000, 1'b0, 1'b0, 1'b0, "R5 slice 7 off");
    access(1'b1, 32'h2000_4000, 1'b0, 1'b0, 1'b1, "R5 slice 2 back on");
  endtask

  task automatic t_priority;
    set_region(4'd0, 32'h2000_0000, 1'b1, 5'd15, 8'h00, 3'd3, 5'h01);
    set_region(4'd1, 32'h2000_2000, 1'b1, 5'd11, 8'h00, 3'd6, 5'h02);
    access(1'b1, 32'h2000_2010, 1'b1, 1'b0, 1'b0, "R6 region 1 read-only");
    access(1'b1, 32'h2000_2010, 1'b0, 1'b0, 1'b1, "R6 region 1 read");
    access(1'b1, 32'h2000_3000, 1'b1, 1'b0, 1'b1, "R6 outside region 1");
    acc_addr = 32'h2000_2010; #1;
    chk(acc_attr === 5'h02, "R6 attr of winner", 32'(acc_attr), 2);
    @(negedge clk);
    set_region(4'd7, 32'h2000_2000, 1'b1, 5'd11, 8'h00, 3'd3, 5'h07);
    access(1'b1, 32'h2000_2010, 1'b1, 1'b0, 1'b1, "R6 region 7 over 1");
    set_region(4'd7, 32'h2000_2000, 1'b0, 5'd11, 8'h00, 3'd3, 5'h07);
    set_region(4'd1, 32'h2000_2000, 1'b0, 5'd11, 8'h00, 3'd6, 5'h02);
  endtask

  task automatic t_size;
    set_region(4'd3, 32'h3000_0040, 1'b1, 5'd4, 8'h00, 3'd3, 5'h04);
    access(1'b1, 32'h3000_0040, 1'b1, 1'b0, 1'b1, "R4 32B low");
    access(1'b1, 32'h3000_005F, 1'b1, 1'b0, 1'b1, "R4 32B high");
    access(1'b1, 32'h3000_0060, 1'b1, 1'b0, 1'b0, "R4 32B above");
    access(1'b1, 32'h3000_003F, 1'b0, 1'b0, 1'b0, "R4 32B below");
    set_region(4'd3, 32'h3000_0040, 1'b1, 5'd3, 8'h00, 3'd3, 5'h04);
    access(1'b1, 32'h3000_0040, 1'b0, 1'b0, 1'b0, "R4 N=3 invalid");
    set_region(4'd15, 32'h0000_0000, 1'b1, 5'd31, 8'h80, 3'd3, 5'h1F);
    access(1'b1, 32'h9000_0000, 1'b1, 1'b0, 1'b1, "R4 4GB region");
    access(1'b1, 32'hF000_0000, 1'b0, 1'b0, 1'b0, "R5 4GB slice 7 off");
    access(1'b1, 32'h2000_0000, 1'b1, 1'b0, 1'b1, "R4 4GB low");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0; acc_priv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_background;
    t_basic;
    t_perm;
    t_slices;
    t_priority;
    t_size;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule